// File: doc/BRIEF.md
# Flash Page Buffer Merge Unit

This unit builds the byte image that a NAND-style array would program into one sector. A sector holds 2112 byte columns. Columns 0 to 2047 form the data area and columns 2048 to 2111 form the control area. For each column, the caller streams the byte the cells hold now, the host byte for that column and a flag saying whether the host supplied one. One clock later, the unit returns the byte that belongs in the page buffer.

A start strobe begins a pass. It latches one of four program modes and a start column, clears the conflict flag and resets the beat counter. Three modes are additional writes:

- one places host data from a given column onward,
- one always places host data from column 0,
- one touches only the control area.

In these three modes a host byte of 0xFF means "leave as is", and a byte may only be written where the cells are still erased. The fourth mode overwrites from the given column, so 0xFF is ordinary data there.

An additional write that would put a non-0xFF byte over a non-0xFF byte keeps the stored byte and sets a sticky conflict flag. A done pulse marks the output of the 2112th beat of a pass.

Top module: `pgbuf_merge`

## Requirements
- R1: After reset, mergedValid, done and conflict are 0 and mergedByte is 0x00.
- R2: In the additional-write modes (mode codes 0, 1 and 2), a host byte of 0xFF leaves the output equal to the stored byte.
- R3: In the additional-write modes, a non-0xFF host byte inside the window over a stored byte of 0xFF appears on the output.
- R4: In the additional-write modes, a non-0xFF host byte inside the window over a non-0xFF stored byte outputs the stored byte and sets conflict, which stays 1 until the next start.
- R5: In overwrite mode (mode code 3), every column inside the window with host data outputs the host byte, 0xFF included, and never sets conflict.
- R6: A column with newValid low outputs its stored byte in every mode.
- R7: The window is column >= startCol in modes 0 and 3. In mode 1 startCol is ignored and the window starts at column 0. Host data outside the window is ignored.
- R8: In mode 2, columns 0 to 2047 output the stored byte whatever the host data is. Columns 2048 to 2111 follow the rules of R2 to R4.
- R9: A beat (inValid high) produces mergedValid high with its merged byte exactly one clock later. Without a beat, mergedValid is low.
- R10: The start strobe clears conflict and the beat counter and latches mode and startCol. A beat in the same cycle as start is merged under the new mode and counts as the first beat of the new pass.
- R11: done is high for one cycle, together with the output of the 2112th beat since start, and does not repeat for later beats of the same pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass: latch mode and startCol, clear conflict and counter |
| mode | input | 2 | 0 add from column, 1 add from zero, 2 control-area add, 3 overwrite |
| startCol | input | 12 | First column of the write window (modes 0 and 3) |
| inValid | input | 1 | A column beat is present this cycle |
| col | input | 12 | Column index of the beat |
| oldByte | input | 8 | Byte currently held by the cells at col |
| newByte | input | 8 | Host byte for col |
| newValid | input | 1 | Host supplied a byte for col |
| mergedByte | output | 8 | Page buffer byte for the previous beat |
| mergedValid | output | 1 | mergedByte carries a result |
| done | output | 1 | Output of the last beat of the pass |
| conflict | output | 1 | Sticky: an additional write hit a programmed byte |

## Verification
Two functions can fire in the same output cycle: conflict detection and the end-of-pass done pulse. To provoke this, a control-area pass runs over a sector that reads 0xFF everywhere except column 2111, where the host also writes a non-0xFF byte. The bench then requires conflict to stay low for every earlier output and to rise in the very cycle that done is high, carrying the stored byte. A second overlap is start together with a beat. Every table vector is issued that way, and the result is judged against the newly latched mode with a freshly cleared flag.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [1:0] {
    MODE_ADD_COL   = 2'd0,
    MODE_ADD_ZERO  = 2'd1,
    MODE_ADD_CTRL  = 2'd2,
    MODE_OVERWRITE = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  clear;
    logic  beat;
    logic  lastBeat;
    mode_e mode;
  } strobe_t;

endpackage

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int NUM_COLS  = 2112,
  parameter int DATA_COLS = 2048,
  parameter int COL_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       modeIn,
  input  logic [COL_W-1:0] startColIn,
  input  logic             inValid,
  output strobe_t          stb,
  output logic [COL_W-1:0] winStart
);
  localparam int CNT_W = $clog2(NUM_COLS + 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(NUM_COLS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_COLS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [COL_W-1:0] CTRL_START = COL_W'(DATA_COLS);

  mode_e            modeQ, effMode;
  logic [COL_W-1:0] startQ, effStart;
  logic [CNT_W-1:0] cnt, cntEff;

  always_comb begin
    effMode  = start ? mode_e'(modeIn) : modeQ;
    effStart = start ? startColIn : startQ;
    cntEff   = start ? '0 : cnt;
    case (effMode)
      MODE_ADD_ZERO: winStart = '0;
      MODE_ADD_CTRL: winStart = CTRL_START;
      default:       winStart = effStart;
    endcase
    stb.clear    = start;
    stb.beat     = inValid;
    stb.lastBeat = inValid && (cntEff == CNT_LAST);
    stb.mode     = effMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_ADD_COL;
      startQ <= '0;
      cnt    <= '0;
    end else begin
      if (start) begin
        modeQ  <= mode_e'(modeIn);
        startQ <= startColIn;
        cnt    <= inValid ? CNT_ONE : '0;
      end else if (inValid && cnt != CNT_END) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (cnt <= CNT_ONE)); // R10

  AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.lastBeat |=> !stb.lastBeat); // R11

endmodule

// File: rtl/pgm_datapath.sv
module pgm_datapath
  import pgm_pkg::*;
#(
  parameter int NUM_COLS  = 2112,
  parameter int DATA_COLS = 2048,
  parameter int BYTE_W    = 8,
  parameter int COL_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [COL_W-1:0]  winStart,
  input  logic [COL_W-1:0]  col,
  input  logic [BYTE_W-1:0] oldByte,
  input  logic [BYTE_W-1:0] newByte,
  input  logic              newValid,
  output logic [BYTE_W-1:0] mergedByte,
  output logic              mergedValid,
  output logic              doneOut,
  output logic              conflictOut
);
  localparam logic [BYTE_W-1:0] ERASED   = '1;
  localparam logic [COL_W-1:0]  LAST_COL = COL_W'(NUM_COLS - 1);
  localparam logic [COL_W-1:0]  CTRL_COL = COL_W'(DATA_COLS);

  logic              inWin, hit;
  logic [BYTE_W-1:0] nextByte;

  always_comb begin
    inWin    = newValid && (col >= winStart) && (col <= LAST_COL);
    nextByte = oldByte;
    hit      = 1'b0;
    if (inWin) begin
      if (stb.mode == MODE_OVERWRITE)  nextByte = newByte;
      else if (newByte == ERASED)      nextByte = oldByte;
      else if (oldByte == ERASED)      nextByte = newByte;
      else                             hit      = stb.beat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mergedByte  <= '0;
      mergedValid <= 1'b0;
      doneOut     <= 1'b0;
      conflictOut <= 1'b0;
    end else begin
      mergedValid <= stb.beat;
      doneOut     <= stb.lastBeat;
      conflictOut <= (stb.clear ? 1'b0 : conflictOut) | hit;
      if (stb.beat) mergedByte <= nextByte;
    end
  end

  AST_FF_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && stb.mode != MODE_OVERWRITE && newByte == ERASED)
      |=> mergedByte == $past(oldByte)); // R2

  AST_OVR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && stb.mode == MODE_OVERWRITE && newValid && col >= winStart)
      |=> (mergedByte == $past(newByte)) && ($past(stb.clear) || $stable(conflictOut))); // R5

  AST_NO_DATA_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && !newValid) |=> mergedByte == $past(oldByte)); // R6

  AST_CTRL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && stb.mode == MODE_ADD_CTRL && col < CTRL_COL)
      |=> mergedByte == $past(oldByte)); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (conflictOut && !stb.clear) |=> conflictOut); // R4

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rstN)
    stb.beat |=> mergedValid); // R9

  AST_NO_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.beat |=> !mergedValid); // R9

  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> mergedValid); // R11

endmodule

// File: rtl/pgbuf_merge.sv
module pgbuf_merge
  import pgm_pkg::*;
#(
  parameter int NUM_COLS  = 2112,
  parameter int DATA_COLS = 2048,
  parameter int BYTE_W    = 8,
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [COL_W-1:0]  startCol,
  input  logic              inValid,
  input  logic [COL_W-1:0]  col,
  input  logic [BYTE_W-1:0] oldByte,
  input  logic [BYTE_W-1:0] newByte,
  input  logic              newValid,
  output logic [BYTE_W-1:0] mergedByte,
  output logic              mergedValid,
  output logic              done,
  output logic              conflict
);
  strobe_t          stb;
  logic [COL_W-1:0] winStart;

  pgm_ctrl #(
    .NUM_COLS(NUM_COLS), .DATA_COLS(DATA_COLS), .COL_W(COL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(mode),
    .startColIn(startCol), .inValid(inValid), .stb(stb), .winStart(winStart)
  );

  pgm_datapath #(
    .NUM_COLS(NUM_COLS), .DATA_COLS(DATA_COLS), .BYTE_W(BYTE_W), .COL_W(COL_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .winStart(winStart), .col(col),
    .oldByte(oldByte), .newByte(newByte), .newValid(newValid),
    .mergedByte(mergedByte), .mergedValid(mergedValid),
    .doneOut(done), .conflictOut(conflict)
  );

endmodule

// File: tb/test_pgbuf_merge.sv
`timescale 1ns/1ps
module test_pgbuf_merge;
  localparam int NCOL = 2112;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = '0;
  logic [11:0] startCol = '0;
  logic       inValid = 1'b0;
  logic [11:0] col = '0;
  logic [7:0] oldByte = '0;
  logic [7:0] newByte = '0;
  logic       newValid = 1'b0;
  logic [7:0] mergedByte;
  logic       mergedValid, done, conflict;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  pgbuf_merge i_pgbuf_merge (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .startCol(startCol),
    .inValid(inValid), .col(col), .oldByte(oldByte), .newByte(newByte),
    .newValid(newValid), .mergedByte(mergedByte), .mergedValid(mergedValid),
    .done(done), .conflict(conflict)
  );

  // {req4, mode2, startCol12, col12, old8, new8, newValid1, expByte8, expConflict1}
  localparam logic [55:0] VECS [NVEC] = '{
    {4'd3,  2'd0, 12'd5,    12'd10,   8'hFF, 8'h3C, 1'b1, 8'h3C, 1'b0}, // R3
    {4'd2,  2'd0, 12'd5,    12'd10,   8'h42, 8'hFF, 1'b1, 8'h42, 1'b0}, // R2
    {4'd4,  2'd0, 12'd5,    12'd10,   8'h42, 8'h3C, 1'b1, 8'h42, 1'b1}, // R4
    {4'd7,  2'd0, 12'd20,   12'd10,   8'hFF, 8'h3C, 1'b1, 8'hFF, 1'b0}, // R7
    {4'd7,  2'd1, 12'd20,   12'd10,   8'hFF, 8'h3C, 1'b1, 8'h3C, 1'b0}, // R7
    {4'd6,  2'd1, 12'd0,    12'd0,    8'h11, 8'h22, 1'b0, 8'h11, 1'b0}, // R6
    {4'd8,  2'd2, 12'd0,    12'd100,  8'hFF, 8'h55, 1'b1, 8'hFF, 1'b0}, // R8
    {4'd8,  2'd2, 12'd0,    12'd2048, 8'hFF, 8'h55, 1'b1, 8'h55, 1'b0}, // R8
    {4'd8,  2'd2, 12'd0,    12'd2111, 8'h77, 8'h55, 1'b1, 8'h77, 1'b1}, // R8
    {4'd5,  2'd3, 12'd0,    12'd7,    8'h42, 8'hFF, 1'b1, 8'hFF, 1'b0}, // R5
    {4'd5,  2'd3, 12'd0,    12'd7,    8'h42, 8'h3C, 1'b1, 8'h3C, 1'b0}, // R5
    {4'd7,  2'd3, 12'd8,    12'd7,    8'h42, 8'h3C, 1'b1, 8'h42, 1'b0}, // R7
    {4'd6,  2'd3, 12'd0,    12'd9,    8'h42, 8'h3C, 1'b0, 8'h42, 1'b0}, // R6
    {4'd2,  2'd1, 12'd0,    12'd2047, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b0}  // R2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench model of the requirements
  function automatic logic [8:0] model(input int m, input int sc, input int c,
                                       input logic [7:0] o, input logic [7:0] n, input bit nv);
    int  ws;
    bit  win;
    ws  = (m == 1) ? 0 : (m == 2) ? 2048 : sc;
    win = nv && (c >= ws);
    if (!win)         return {o, 1'b0};
    if (m == 3)       return {n, 1'b0};
    if (n == 8'hFF)   return {o, 1'b0};
    if (o == 8'hFF)   return {n, 1'b0};
    return {o, 1'b1};
  endfunction

  function automatic logic [7:0] patOld(input int kind, input int c);
    case (kind)
      0: return (c % 4 == 0) ? 8'hFF : 8'h10;
      1: return 8'(c);
      default: return (c == NCOL - 1) ? 8'h33 : 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] patNew(input int kind, input int c);
    case (kind)
      0: return (c % 4 == 1) ? 8'hFF : 8'hA5;
      1: return (c % 2 == 1) ? 8'hFF : 8'hC3;
      default: return 8'hA5;
    endcase
  endfunction

  task automatic runPass(input int kind, input int m, input int sc, input string req);
    int  byteErr = 0, doneErr = 0, confErr = 0;
    bit  expConf = 1'b0;
    bit  lateConf = 1'b0;
    logic [8:0] r;
    for (int c = 0; c <= NCOL; c++) begin
      @(negedge clk);
      if (c > 0) begin
        r = model(m, sc, c - 1, patOld(kind, c - 1), patNew(kind, c - 1), 1'b1);
        expConf = expConf | r[0];
        if (mergedByte != r[8:1] || !mergedValid) begin
          if (byteErr == 0)
            $display("FAIL %s col %0d byte actual=0x%0h expected=0x%0h", req, c - 1, mergedByte, r[8:1]);
          byteErr++;
        end
        if (done != (c == NCOL)) begin
          if (doneErr == 0)
            $display("FAIL R11 col %0d done actual=%0d expected=%0d", c - 1, done, (c == NCOL));
          doneErr++;
        end
        if (conflict != expConf) begin
          if (confErr == 0)
            $display("FAIL R4 col %0d conflict actual=%0d expected=%0d", c - 1, conflict, expConf);
          confErr++;
        end
        if (kind == 2 && c == NCOL) lateConf = conflict && done;
      end
      if (c < NCOL) begin
        start = (c == 0); mode = 2'(m); startCol = 12'(sc);
        inValid = 1'b1; col = 12'(c);
        oldByte = patOld(kind, c); newByte = patNew(kind, c); newValid = 1'b1;
      end else begin
        start = 1'b0; inValid = 1'b0;
      end
    end
    testsRun += 3;
    if (byteErr != 0) testsFailed++;
    if (doneErr != 0) testsFailed++;
    if (confErr != 0) testsFailed++;
    if (kind == 2) check(lateConf, "R4/R11 conflict with done", lateConf, 1);
  endtask

  initial begin
    #1_000_000;
    testsFailed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!mergedValid && !done && !conflict && mergedByte == 8'h00, "R1 reset",
          {mergedValid, done, conflict, mergedByte}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: each vector issued with start in the same cycle (R10)
    for (int i = 0; i < NVEC; i++) begin
      start = 1'b1; mode = VECS[i][51:50]; startCol = VECS[i][49:38];
      inValid = 1'b1; col = VECS[i][37:26]; oldByte = VECS[i][25:18];
      newByte = VECS[i][17:10]; newValid = VECS[i][9];
      @(negedge clk);
      start = 1'b0; inValid = 1'b0;
      check(mergedValid && mergedByte == VECS[i][8:1],
            $sformatf("R%0d vector %0d byte", VECS[i][55:52], i), mergedByte, VECS[i][8:1]);
      check(conflict == VECS[i][0],
            $sformatf("R%0d vector %0d conflict", VECS[i][55:52], i), conflict, VECS[i][0]);
      @(negedge clk);
    end

    // R4 stickiness, R9 idle, R10 clear by start alone
    start = 1'b1; mode = 2'd0; startCol = 12'd0; inValid = 1'b1; col = 12'd3;
    oldByte = 8'h42; newByte = 8'h24; newValid = 1'b1;
    @(negedge clk);
    start = 1'b0; oldByte = 8'hFF; newByte = 8'hFF; col = 12'd4;
    @(negedge clk);
    check(conflict == 1'b1 && mergedByte == 8'hFF, "R4 sticky", conflict, 1);
    inValid = 1'b0;
    @(negedge clk);
    check(!mergedValid, "R9 no beat no valid", mergedValid, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(conflict == 1'b0, "R10 start clears conflict", conflict, 0);

    // full passes
    runPass(0, 0, 0, "R3 pass");
    runPass(1, 3, 2100, "R5 pass");
    runPass(2, 2, 0, "R8 pass");

    // R11: an extra beat after the pass must not repeat done
    inValid = 1'b1; newValid = 1'b0; col = 12'd0; oldByte = 8'h5A;
    @(negedge clk);
    inValid = 1'b0;
    check(!done && mergedValid && mergedByte == 8'h5A, "R11 no repeat done", done, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule